// File: doc/BRIEF.md
# Instruction Byte Queue with Folding Decoder

This block sits between instruction fetch and execution in a stack-machine pipeline. Fetch pushes up to four code bytes per cycle into a twelve-byte queue. Each cycle the decoder looks at the first five bytes at the head of the queue and issues one instruction, or two merged instructions, to the execution stage. Execution takes every issue, so the consumed bytes leave the queue in the same cycle.

Two pairs are merged into one compound operation. The first pair is a local-variable load followed by an instruction that consumes the top of stack. The second pair is a small-constant push followed by such a consumer. In the merged operation the consumer takes its operand straight from the stack slot of the local, or from the decoded immediate. Nothing is pushed first. Merging is dropped while single-step mode is on, and for a load whose local is not held in the stack cache. The decoder presents the local's index on `lv_query_idx`. The stack cache answers in the same cycle on `lv_present`. A flush empties the queue after a taken branch.

Top module: `fold_ibuf`

## Requirements
- R1: After reset the queue is empty: `iss_valid` is 0, `lv_query_idx` is 0, and a write of 1 to 4 bytes is accepted.
- R2: A write is accepted (`wr_accept`=1) only if `wr_valid` is 1, `flush` is 0, `wr_cnt` is at most 4, and `wr_cnt` is no larger than 12 minus the bytes held at the start of the cycle. A refused write leaves the queue unchanged.
- R3: An instruction is issued only when all of its bytes are in the queue. Otherwise `iss_valid` is 0 and no bytes are consumed.
- R4: The decoded subset has these lengths. 0x1A-0x1D: load of local 0-3, 1 byte. 0x15: load of local byte1, 2 bytes. 0x02-0x08: push of constant opcode-3, 1 byte. 0x10: push of sign-extended byte1, 2 bytes. 0x60, 0x64, 0x7E, 0x80: consumers, 1 byte. 0x36: consumer, 2 bytes. 0xA7: 3 bytes. 0xB9: 5 bytes. Every other opcode: 1 byte. `iss_len` is the length of the lone instruction, or the sum of both lengths for a merged pair. `iss_arg` is byte1 of the instruction named by `iss_op`, or 0 when that instruction has no operand byte.
- R5: A load followed by a complete consumer, with `lv_present`=1, issues as one merged operation. In it `iss_folded`=1, `iss_op` is the consumer's opcode, `iss_src`=1 (local), and `iss_srcval` is the local index.
- R6: A constant push followed by a complete consumer issues as one merged operation. In it `iss_src`=2 (immediate) and `iss_srcval` is the 32-bit constant.
- R7: With `lv_present`=0 the load issues alone, with `iss_folded`=0.
- R8: With `single_step`=1 no merge takes place.
- R9: A load or constant issues alone if the bytes after it do not form a complete consumer. A lone issue has `iss_src`=0 (stack) and `iss_srcval`=0.
- R10: With `flush`=1, `iss_valid` and `wr_accept` are 0 in that cycle, and the queue is empty in the next cycle.
- R11: Bytes leave the queue in the order they were written. Byte `wr_data[7:0]` comes first in program order.
- R12: `lv_query_idx` gives the local index of a complete load at the head, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the queue (taken branch) |
| wr_valid | input | 1 | Fetch offers bytes |
| wr_cnt | input | 3 | Number of bytes offered (1-4) |
| wr_data | input | 32 | Offered bytes, first byte in bits 7:0 |
| wr_accept | output | 1 | Offered bytes are taken this cycle |
| single_step | input | 1 | Debug single-step, disables merging |
| lv_present | input | 1 | The local at `lv_query_idx` is in the stack cache |
| lv_query_idx | output | 8 | Local index of the head load |
| iss_valid | output | 1 | An issue takes place this cycle |
| iss_op | output | 8 | Opcode issued (the consumer's opcode when merged) |
| iss_arg | output | 8 | Operand byte of the issued opcode |
| iss_src | output | 2 | Operand source: 0 stack, 1 local, 2 immediate |
| iss_srcval | output | 32 | Local index or constant value |
| iss_folded | output | 1 | The issue is a merged pair |
| iss_len | output | 3 | Bytes consumed this cycle |

## Verification
The hardest states to reach are the ones where the head holds a partial instruction while the queue is nearly full. In those states a merge waits on bytes that fetch is not yet allowed to write. A run of one-byte non-merging opcodes, offered four bytes at a time, drains more slowly than it fills. This brings the queue up to the refusal point in a known cycle. Random streams are built mostly from the decoded subset, with rare flushes and single-step cycles. They reach split pairs, five-byte instructions that end across writes, and local misses. A bench model of the byte queue predicts every output in every cycle.

// File: rtl/fold_ibuf_pkg.sv
package fold_ibuf_pkg;

    typedef enum logic [1:0] {
        CL_OTHER = 2'd0,
        CL_LOAD  = 2'd1,
        CL_CONST = 2'd2,
        CL_USE   = 2'd3
    } op_class_e;

    typedef enum logic [1:0] {
        SRC_STACK = 2'd0,
        SRC_LOCAL = 2'd1,
        SRC_IMM   = 2'd2
    } src_kind_e;

    typedef struct packed {
        op_class_e  cls;
        logic [2:0] len;
    } op_info_t;

    // Class and byte length of one opcode of the decoded subset
    function automatic op_info_t classify(input logic [7:0] op);
        op_info_t r;
        r.cls = CL_OTHER;
        r.len = 3'd1;
        case (op)
            8'h1A, 8'h1B, 8'h1C, 8'h1D: r.cls = CL_LOAD;
            8'h15: begin r.cls = CL_LOAD; r.len = 3'd2; end
            8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08: r.cls = CL_CONST;
            8'h10: begin r.cls = CL_CONST; r.len = 3'd2; end
            8'h60, 8'h64, 8'h7E, 8'h80: r.cls = CL_USE;
            8'h36: begin r.cls = CL_USE; r.len = 3'd2; end
            8'hA7: r.len = 3'd3;
            8'hB9: r.len = 3'd5;
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fold_ibuf_queue.sv
module fold_ibuf_queue #(
    parameter int DEPTH    = 12,
    parameter int WR_BYTES = 4,
    parameter int WIN      = 5,
    parameter int CW       = $clog2(DEPTH + 1),
    parameter int WCW      = $clog2(WR_BYTES + 1),
    parameter int LW       = $clog2(WIN + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic                  wr_valid,
    input  logic [WCW-1:0]        wr_cnt,
    input  logic [WR_BYTES*8-1:0] wr_data,
    input  logic [LW-1:0]         pop_len,
    output logic                  wr_accept,
    output logic [WIN*8-1:0]      win,
    output logic [CW-1:0]         fill
);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] bytes;
        logic [CW-1:0]         fill;
    } qstate_t;

    qstate_t st_d, st_q;

    always_comb begin
        int keep;
        int room;
        st_d = st_q;
        room = DEPTH - int'(st_q.fill);
        wr_accept = wr_valid && !flush && (int'(wr_cnt) <= WR_BYTES)
                    && (int'(wr_cnt) <= room);
        keep = int'(st_q.fill) - int'(pop_len);
        for (int i = 0; i < DEPTH; i++) begin
            st_d.bytes[i] = 8'h00;
            if (i < keep) begin
                st_d.bytes[i] = st_q.bytes[i + int'(pop_len)];
            end else if (wr_accept && ((i - keep) < int'(wr_cnt))) begin
                st_d.bytes[i] = wr_data[(i - keep)*8 +: 8];
            end
        end
        if (flush) begin
            st_d.fill = '0;
        end else begin
            st_d.fill = CW'(keep + (wr_accept ? int'(wr_cnt) : 0));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar k = 0; k < WIN; k++) begin : g_win
        assign win[k*8 +: 8] = st_q.bytes[k];
    end

    assign fill = st_q.fill;

endmodule

// File: rtl/fold_ibuf_decode.sv
module fold_ibuf_decode
    import fold_ibuf_pkg::*;
#(
    parameter int WIN = 5,
    parameter int CW  = 4,
    parameter int LW  = 3
) (
    input  logic [WIN*8-1:0] win,
    input  logic [CW-1:0]    fill,
    input  logic             flush,
    input  logic             single_step,
    input  logic             lv_present,
    output logic [7:0]       lv_query_idx,
    output logic             iss_valid,
    output logic [7:0]       iss_op,
    output logic [7:0]       iss_arg,
    output logic [1:0]       iss_src,
    output logic [31:0]      iss_srcval,
    output logic             iss_folded,
    output logic [LW-1:0]    pop_len
);

    logic [7:0] b [WIN];
    op_info_t   head_i, next_i;
    logic [7:0] next_op, next_arg, lv_idx;
    logic       have_head, have_pair, feeder, do_fold;
    logic [31:0] imm;

    for (genvar k = 0; k < WIN; k++) begin : g_b
        assign b[k] = win[k*8 +: 8];
    end

    always_comb begin
        head_i    = classify(b[0]);
        have_head = (fill != '0) && (int'(fill) >= int'(head_i.len));
        next_op   = (head_i.len == 3'd2) ? b[2] : b[1];
        next_arg  = (head_i.len == 3'd2) ? b[3] : b[2];
        next_i    = classify(next_op);
        have_pair = int'(fill) >= (int'(head_i.len) + int'(next_i.len));
        lv_idx    = (head_i.len == 3'd2) ? b[1] : (b[0] - 8'h1A);
        if (head_i.len == 3'd2) imm = {{24{b[1][7]}}, b[1]};
        else                    imm = {24'h0, b[0]} - 32'd3;
        feeder  = ((head_i.cls == CL_LOAD) && lv_present) || (head_i.cls == CL_CONST);
        do_fold = have_head && feeder && (next_i.cls == CL_USE) && have_pair
                  && !single_step && !flush;

        lv_query_idx = (have_head && head_i.cls == CL_LOAD) ? lv_idx : 8'h00;
        iss_valid    = have_head && !flush;
        iss_folded   = do_fold;
        iss_op       = 8'h00;
        iss_arg      = 8'h00;
        iss_src      = SRC_STACK;
        iss_srcval   = 32'h0;
        pop_len      = '0;
        if (do_fold) begin
            iss_op  = next_op;
            iss_arg = (next_i.len == 3'd2) ? next_arg : 8'h00;
            if (head_i.cls == CL_LOAD) begin
                iss_src    = SRC_LOCAL;
                iss_srcval = {24'h0, lv_idx};
            end else begin
                iss_src    = SRC_IMM;
                iss_srcval = imm;
            end
            pop_len = LW'(int'(head_i.len) + int'(next_i.len));
        end else if (iss_valid) begin
            iss_op  = b[0];
            iss_arg = (head_i.len >= 3'd2) ? b[1] : 8'h00;
            pop_len = LW'(head_i.len);
        end
    end

endmodule

// File: rtl/fold_ibuf.sv
module fold_ibuf #(
    parameter int DEPTH    = 12,
    parameter int WR_BYTES = 4,
    parameter int WIN      = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic        wr_valid,
    input  logic [2:0]  wr_cnt,
    input  logic [31:0] wr_data,
    output logic        wr_accept,
    input  logic        single_step,
    input  logic        lv_present,
    output logic [7:0]  lv_query_idx,
    output logic        iss_valid,
    output logic [7:0]  iss_op,
    output logic [7:0]  iss_arg,
    output logic [1:0]  iss_src,
    output logic [31:0] iss_srcval,
    output logic        iss_folded,
    output logic [2:0]  iss_len
);

    localparam int CW  = $clog2(DEPTH + 1);
    localparam int WCW = 3;
    localparam int LW  = 3;

    logic [WIN*8-1:0] q_win;
    logic [CW-1:0]    q_fill;
    logic [LW-1:0]    pop_len;

    fold_ibuf_queue #(
        .DEPTH(DEPTH), .WR_BYTES(WR_BYTES), .WIN(WIN),
        .CW(CW), .WCW(WCW), .LW(LW)
    ) u_queue (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_valid(wr_valid), .wr_cnt(wr_cnt), .wr_data(wr_data),
        .pop_len(pop_len), .wr_accept(wr_accept),
        .win(q_win), .fill(q_fill)
    );

    fold_ibuf_decode #(.WIN(WIN), .CW(CW), .LW(LW)) u_dec (
        .win(q_win), .fill(q_fill), .flush(flush),
        .single_step(single_step), .lv_present(lv_present),
        .lv_query_idx(lv_query_idx), .iss_valid(iss_valid),
        .iss_op(iss_op), .iss_arg(iss_arg), .iss_src(iss_src),
        .iss_srcval(iss_srcval), .iss_folded(iss_folded), .pop_len(pop_len)
    );

    assign iss_len = pop_len;

endmodule

// File: rtl/fold_ibuf_chk.sv
module fold_ibuf_chk #(
    parameter int DEPTH = 12,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic          wr_valid,
    input logic [2:0]    wr_cnt,
    input logic          wr_accept,
    input logic          single_step,
    input logic          lv_present,
    input logic          iss_valid,
    input logic          iss_folded,
    input logic [1:0]    iss_src,
    input logic [2:0]    iss_len,
    input logic [CW-1:0] fill
);

    // R2
    refuse_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && (int'(wr_cnt) > DEPTH - int'(fill))) |-> !wr_accept);

    // R10
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!iss_valid && !wr_accept));

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fill == '0));

    // R8
    step_nofold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        single_step |-> !iss_folded);

    // R7
    miss_nofold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_folded && iss_src == 2'd1) |-> lv_present);

    // R3
    complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (int'(iss_len) <= int'(fill)));

    // R4
    fill_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !flush) |=> (int'(fill) == int'($past(fill)) - int'($past(iss_len))
            + ($past(wr_accept) ? int'($past(wr_cnt)) : 0)));

endmodule

bind fold_ibuf fold_ibuf_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_valid(wr_valid),
    .wr_cnt(wr_cnt), .wr_accept(wr_accept), .single_step(single_step),
    .lv_present(lv_present), .iss_valid(iss_valid), .iss_folded(iss_folded),
    .iss_src(iss_src), .iss_len(iss_len), .fill(q_fill)
);

// File: tb/sim_fold_ibuf.sv
`timescale 1ns/1ps
module sim_fold_ibuf;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        wr_valid = 1'b0;
    logic [2:0]  wr_cnt = 3'd0;
    logic [31:0] wr_data = 32'h0;
    logic        wr_accept;
    logic        single_step = 1'b0;
    logic        lv_present = 1'b0;
    logic [7:0]  lv_query_idx;
    logic        iss_valid;
    logic [7:0]  iss_op;
    logic [7:0]  iss_arg;
    logic [1:0]  iss_src;
    logic [31:0] iss_srcval;
    logic        iss_folded;
    logic [2:0]  iss_len;

    always #2 clk = ~clk;

    fold_ibuf u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr_valid(wr_valid),
        .wr_cnt(wr_cnt), .wr_data(wr_data), .wr_accept(wr_accept),
        .single_step(single_step), .lv_present(lv_present),
        .lv_query_idx(lv_query_idx), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_arg(iss_arg), .iss_src(iss_src), .iss_srcval(iss_srcval),
        .iss_folded(iss_folded), .iss_len(iss_len)
    );

    int n_run = 0;
    int n_fail = 0;

    // bench model of the byte queue
    logic [7:0] mq [0:15];
    int mfill = 0;
    logic        e_valid, e_fold, e_acc;
    logic [7:0]  e_op, e_arg, e_qidx;
    logic [1:0]  e_src;
    logic [31:0] e_val;
    int          e_len;

    // R4 lengths
    function automatic int blen(input logic [7:0] op);
        if (op == 8'h15 || op == 8'h10 || op == 8'h36) return 2;
        if (op == 8'hA7) return 3;
        if (op == 8'hB9) return 5;
        return 1;
    endfunction

    // 1 load, 2 constant, 3 consumer, 0 other
    function automatic int bcls(input logic [7:0] op);
        if ((op >= 8'h1A && op <= 8'h1D) || op == 8'h15) return 1;
        if ((op >= 8'h02 && op <= 8'h08) || op == 8'h10) return 2;
        if (op == 8'h60 || op == 8'h64 || op == 8'h7E || op == 8'h80 || op == 8'h36) return 3;
        return 0;
    endfunction

    task automatic model_eval(input logic wv, input int wc, input logic lv,
                              input logic ss, input logic fl);
        int l0, l1, c0, c1;
        logic [7:0] nop, narg, idx;
        l0 = blen(mq[0]);
        c0 = bcls(mq[0]);
        nop  = mq[l0];
        narg = mq[l0 + 1];
        l1 = blen(nop);
        c1 = bcls(nop);
        idx = (l0 == 2) ? mq[1] : mq[0] - 8'h1A;
        e_acc   = wv && !fl && wc <= 4 && wc <= 12 - mfill;
        e_valid = !fl && mfill > 0 && mfill >= l0;
        e_qidx  = (mfill > 0 && mfill >= l0 && c0 == 1) ? idx : 8'h00;
        e_fold  = e_valid && !ss && c1 == 3 && mfill >= l0 + l1
                  && ((c0 == 1 && lv) || c0 == 2);
        e_op = 8'h00; e_arg = 8'h00; e_src = 2'd0; e_val = 32'h0; e_len = 0;
        if (e_fold) begin
            e_op  = nop;
            e_arg = (l1 == 2) ? narg : 8'h00;
            e_len = l0 + l1;
            if (c0 == 1) begin
                e_src = 2'd1;
                e_val = {24'h0, idx};
            end else begin
                e_src = 2'd2;
                if (l0 == 2) e_val = {{24{mq[1][7]}}, mq[1]};
                else         e_val = 32'(int'(mq[0]) - 3);
            end
        end else if (e_valid) begin
            e_op  = mq[0];
            e_arg = (l0 >= 2) ? mq[1] : 8'h00;
            e_len = l0;
        end
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic wv, input int wc, input logic [31:0] wd,
                        input logic lv, input logic ss, input logic fl);
        @(posedge clk);
        #1;
        wr_valid = wv; wr_cnt = 3'(wc); wr_data = wd;
        lv_present = lv; single_step = ss; flush = fl;
        model_eval(wv, wc, lv, ss, fl);
        @(negedge clk);
        check("R2",  "wr_accept",    {31'h0, wr_accept},  {31'h0, e_acc});
        check("R3",  "iss_valid",    {31'h0, iss_valid},  {31'h0, e_valid});
        check("R11", "iss_op",       {24'h0, iss_op},     {24'h0, e_op});
        check("R4",  "iss_arg",      {24'h0, iss_arg},    {24'h0, e_arg});
        check("R4",  "iss_len",      {29'h0, iss_len},    32'(e_len));
        check("R9",  "iss_folded",   {31'h0, iss_folded}, {31'h0, e_fold});
        check("R5",  "iss_src",      {30'h0, iss_src},    {30'h0, e_src});
        check("R6",  "iss_srcval",   iss_srcval,          e_val);
        check("R12", "lv_query_idx", {24'h0, lv_query_idx}, {24'h0, e_qidx});
        if (fl) begin
            mfill = 0;
        end else begin
            if (e_valid) begin
                for (int i = 0; i < 16; i++)
                    mq[i] = (i + e_len < 16) ? mq[i + e_len] : 8'h00;
                mfill -= e_len;
            end
            if (e_acc) begin
                for (int j = 0; j < wc; j++) mq[mfill + j] = wd[j*8 +: 8];
                mfill += wc;
            end
        end
        for (int i = mfill; i < 16; i++) mq[i] = 8'h00;
    endtask

    function automatic logic [7:0] pick_byte();
        int r;
        r = int'($urandom % 22);
        case (r)
            0: return 8'h1A;  1: return 8'h1B;  2: return 8'h1C;  3: return 8'h1D;
            4: return 8'h15;  5: return 8'h02;  6: return 8'h05;  7: return 8'h08;
            8: return 8'h10;  9: return 8'h60; 10: return 8'h64; 11: return 8'h7E;
            12: return 8'h80; 13: return 8'h36; 14: return 8'hA7; 15: return 8'hB9;
            16: return 8'h60; 17: return 8'h64;
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) mq[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        step(1'b0, 0, 32'h0, 1'b1, 1'b0, 1'b0);
        check("R1", "iss_valid after reset", {31'h0, iss_valid}, 32'h0);
        check("R1", "lv_query_idx after reset", {24'h0, lv_query_idx}, 32'h0);

        // R5 load + add folded
        step(1'b1, 2, 32'h0000_601A, 1'b1, 1'b0, 1'b0);
        step(1'b0, 0, 32'h0, 1'b1, 1'b0, 1'b0);
        check("R5", "fold load", {31'h0, iss_folded}, 32'h1);
        check("R5", "fold op", {24'h0, iss_op}, 32'h60);
        check("R5", "fold src", {30'h0, iss_src}, 32'h1);
        check("R5", "fold len", {29'h0, iss_len}, 32'h2);

        // R7 local miss
        step(1'b1, 2, 32'h0000_601B, 1'b0, 1'b0, 1'b0);
        step(1'b0, 0, 32'h0, 1'b0, 1'b0, 1'b0);
        check("R7", "miss not folded", {31'h0, iss_folded}, 32'h0);
        check("R7", "miss op", {24'h0, iss_op}, 32'h1B);
        check("R12", "query idx", {24'h0, lv_query_idx}, 32'h1);
        step(1'b0, 0, 32'h0, 1'b0, 1'b0, 1'b0);

        // R8 single-step
        step(1'b1, 2, 32'h0000_6405, 1'b1, 1'b1, 1'b0);
        step(1'b0, 0, 32'h0, 1'b1, 1'b1, 1'b0);
        check("R8", "single-step not folded", {31'h0, iss_folded}, 32'h0);
        check("R8", "single-step op", {24'h0, iss_op}, 32'h05);
        step(1'b0, 0, 32'h0, 1'b1, 1'b0, 1'b0);

        // R6 constant fold with negative byte immediate
        step(1'b1, 3, 32'h0064_FE10, 1'b1, 1'b0, 1'b0);
        step(1'b0, 0, 32'h0, 1'b1, 1'b0, 1'b0);
        check("R6", "const fold", {31'h0, iss_folded}, 32'h1);
        check("R6", "const value", iss_srcval, 32'hFFFF_FFFE);
        check("R6", "const len", {29'h0, iss_len}, 32'h3);

        // R9 consumer not yet present
        step(1'b1, 1, 32'h0000_001A, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1, 32'h0000_0060, 1'b1, 1'b0, 1'b0);
        check("R9", "lone load", {31'h0, iss_folded}, 32'h0);
        check("R9", "lone load len", {29'h0, iss_len}, 32'h1);
        step(1'b0, 0, 32'h0, 1'b1, 1'b0, 1'b0);

        // R3 five-byte instruction split across writes
        step(1'b1, 4, 32'h0302_01B9, 1'b1, 1'b0, 1'b0);
        step(1'b0, 0, 32'h0, 1'b1, 1'b0, 1'b0);
        check("R3", "incomplete held", {31'h0, iss_valid}, 32'h0);
        step(1'b1, 1, 32'h0000_0004, 1'b1, 1'b0, 1'b0);
        step(1'b0, 0, 32'h0, 1'b1, 1'b0, 1'b0);
        check("R3", "complete issued", {31'h0, iss_valid}, 32'h1);
        check("R4", "five-byte len", {29'h0, iss_len}, 32'h5);
        check("R4", "five-byte arg", {24'h0, iss_arg}, 32'h01);

        // R2 refusal near full
        step(1'b1, 4, 32'h0, 1'b1, 1'b0, 1'b0);
        step(1'b1, 4, 32'h0, 1'b1, 1'b0, 1'b0);
        step(1'b1, 4, 32'h0, 1'b1, 1'b0, 1'b0);
        step(1'b1, 4, 32'h0, 1'b1, 1'b0, 1'b0);
        check("R2", "refused when short of room", {31'h0, wr_accept}, 32'h0);

        // R10 flush
        step(1'b1, 1, 32'h0, 1'b1, 1'b0, 1'b1);
        check("R10", "no issue on flush", {31'h0, iss_valid}, 32'h0);
        step(1'b0, 0, 32'h0, 1'b1, 1'b0, 1'b0);
        check("R10", "empty after flush", {31'h0, iss_valid}, 32'h0);

        // random stream, R11 order checked each cycle
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] d;
            d = {pick_byte(), pick_byte(), pick_byte(), pick_byte()};
            step(($urandom % 4) != 0, 1 + int'($urandom % 4), d,
                 ($urandom % 4) != 0, ($urandom % 16) == 0, ($urandom % 40) == 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule